// File: doc/BRIEF.md
# Predicated 32-bit Data-Processing Unit

This unit performs one 32-bit data-processing operation per clock. It adds, subtracts, compares or applies a logic function to a first operand and a second operand. The second operand comes from a register value or from an immediate value, and it can be shifted left or right by up to 31 places before use.

Every operation carries a 4-bit condition code. The code is tested against four stored flags: Negative, Zero, Carry and Overflow. If the test fails, the operation is dropped entirely: nothing is written and no flag changes.

On each rising clock edge the unit registers the result, a write-enable for a downstream register file and the updated flags. The flags feed the condition test of the next operation, so a compare followed by a conditional operation works without any extra logic.

Top module: `cond_alu`

## Requirements
- R1: When the condition test fails, the next cycle shows `wr_en_o` low, and `result_o` and `status_o` keep their previous values.
- R2: The condition encodings work as follows. 0 passes when Z=1 and 1 passes when Z=0. 2 passes when C=1 and 3 passes when C=0. 4 passes when N=1 and 5 passes when N=0. 6 passes when V=1 and 7 passes when V=0. 8 passes when C=1 and Z=0, and 9 is its inverse. 10 passes when N=V, and 11 is its inverse. 12 passes when Z=0 and N=V, and 13 is its inverse. 14 always passes. 15 never passes.
- R3: `status_o` holds the flags N, Z, C and V in bits 31, 30, 29 and 28 respectively. Bits 27..0 are always 0. Reset clears the flags, `result_o` and `wr_en_o` to 0.
- R4: Opcode 0 is add and opcode 1 is subtract (first minus second). For these operations C is the carry out; for subtract, C is the inverse of the borrow. V is the signed overflow, N is bit 31 of the result, and Z is 1 when the result is 0.
- R5: Opcodes 2 to 7 are AND, OR, XOR, bit-clear (first AND NOT second), move (second operand) and move-negated (NOT second operand). For example, bit-clear of 0x02FA62CA with 0x0000FFFF gives 0x02FA0000. Opcodes 9 to 15 neither write nor change any flag.
- R6: Opcodes 0 to 7 change the flags only when `set_flags_i` is 1.
- R7: Opcode 8 is compare. It computes first minus second and sets all four flags exactly as subtract does, regardless of `set_flags_i`. It never raises `wr_en_o`.
- R8: `use_imm_i` selects `opb_imm_i` (1) or `opb_reg_i` (0) as the second operand. The selected value is shifted by `shift_amt_i` places, to the left when `shift_right_i` is 0 and logically to the right when it is 1.
- R9: A logic operation or move with `set_flags_i` set updates N and Z from the result. It loads C with the last bit shifted out, or leaves C unchanged when the shift amount is 0. It always leaves V unchanged.
- R10: The result and write-enable of an operation appear one clock edge after its inputs are presented. `result_o` changes only on an executed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| cond_i | input | 4 | Condition code |
| set_flags_i | input | 1 | Allow the operation to update the flags |
| use_imm_i | input | 1 | Select the immediate as the second operand |
| shift_right_i | input | 1 | Shift direction: 0 left, 1 logical right |
| shift_amt_i | input | 5 | Shift amount |
| opa_i | input | 32 | First operand |
| opb_reg_i | input | 32 | Register form of the second operand |
| opb_imm_i | input | 32 | Immediate form of the second operand |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Registered result write-enable |
| status_o | output | 32 | Status word with the flags in bits 31..28 |

## Verification
A corrupted flag register shows up at `status_o` one edge after the bad update. It also shows up at `wr_en_o` on the very next predicated operation, because a condition that should pass or fail then does the opposite.

The vector sequence deliberately chains operations: every conditional step depends on flags left by earlier steps. A wrong C, V or Z bit therefore propagates into later write-enable and result mismatches within one or two vectors.

Dropped operations are checked through the held `result_o` and `status_o`, which must not move.

// File: rtl/cond_alu.sv
module cond_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [3:0]   cond_i,
  input  logic         set_flags_i,
  input  logic         use_imm_i,
  input  logic         shift_right_i,
  input  logic [4:0]   shift_amt_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_reg_i,
  input  logic [W-1:0] opb_imm_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [W-1:0] status_o
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_ORR = 4'd3,
                         OP_EOR = 4'd4, OP_BIC = 4'd5, OP_MOV = 4'd6, OP_MVN = 4'd7,
                         OP_CMP = 4'd8;
  localparam logic [3:0] CC_NEVER = 4'hF, CC_ALWAYS = 4'hE;

  logic [3:0] flags_q;
  wire fn = flags_q[3], fz = flags_q[2], fc = flags_q[1], fv = flags_q[0];

  logic base_ok, pass;
  always_comb begin
    case (cond_i[3:1])
      3'd0: base_ok = fz;
      3'd1: base_ok = fc;
      3'd2: base_ok = fn;
      3'd3: base_ok = fv;
      3'd4: base_ok = fc & ~fz;
      3'd5: base_ok = (fn == fv);
      3'd6: base_ok = ~fz & (fn == fv);
      default: base_ok = 1'b1;
    endcase
    pass = (cond_i[3:1] == 3'd7) ? ~cond_i[0] : (base_ok ^ cond_i[0]);
  end

  wire [W-1:0] opb_sel = use_imm_i ? opb_imm_i : opb_reg_i;
  wire [W:0]   shl = {1'b0, opb_sel} << shift_amt_i;
  wire [W:0]   shr = {opb_sel, 1'b0} >> shift_amt_i;
  wire [W-1:0] opb = shift_right_i ? shr[W:1] : shl[W-1:0];
  wire         sh_c = (shift_amt_i == 5'd0) ? fc : (shift_right_i ? shr[0] : shl[W]);

  wire [W:0] add_full = {1'b0, opa_i} + {1'b0, opb};
  wire [W:0] sub_full = {1'b0, opa_i} + {1'b0, ~opb} + {{W{1'b0}}, 1'b1};
  wire add_v = (opa_i[W-1] == opb[W-1]) && (add_full[W-1] != opa_i[W-1]);
  wire sub_v = (opa_i[W-1] != opb[W-1]) && (sub_full[W-1] != opa_i[W-1]);

  logic [W-1:0] alu_res;
  logic [3:0]   next_flags;
  logic         writes, upd_flags;
  always_comb begin
    alu_res    = '0;
    next_flags = flags_q;
    writes     = (op_i <= OP_MVN);
    upd_flags  = 1'b0;
    case (op_i)
      OP_ADD: alu_res = add_full[W-1:0];
      OP_SUB, OP_CMP: alu_res = sub_full[W-1:0];
      OP_AND: alu_res = opa_i & opb;
      OP_ORR: alu_res = opa_i | opb;
      OP_EOR: alu_res = opa_i ^ opb;
      OP_BIC: alu_res = opa_i & ~opb;
      OP_MOV: alu_res = opb;
      OP_MVN: alu_res = ~opb;
      default: alu_res = '0;
    endcase
    if (op_i == OP_ADD) begin
      next_flags = {alu_res[W-1], alu_res == '0, add_full[W], add_v};
      upd_flags  = set_flags_i;
    end else if (op_i == OP_SUB || op_i == OP_CMP) begin
      next_flags = {alu_res[W-1], alu_res == '0, sub_full[W], sub_v};
      upd_flags  = set_flags_i | (op_i == OP_CMP);
    end else if (writes) begin
      next_flags = {alu_res[W-1], alu_res == '0, sh_c, fv};
      upd_flags  = set_flags_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      result_o <= '0;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= pass & writes;
      if (pass && writes) result_o <= alu_res;
      if (pass && upd_flags) flags_q <= next_flags;
    end
  end

  assign status_o = {flags_q, {(W-4){1'b0}}};

  // R1
  never_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == CC_NEVER) |=> (!wr_en_o && $stable(status_o) && $stable(result_o)));
  // R7
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |=> !wr_en_o);
  // R6
  flags_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags_i && op_i != OP_CMP) |=> $stable(status_o));
  // R9
  logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= OP_AND && op_i <= OP_MVN) |=> $stable(status_o[W-4]));
  // R2
  always_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == CC_ALWAYS && op_i <= OP_MVN) |=> wr_en_o);
  // R4
  add_zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == CC_ALWAYS && op_i == OP_ADD && set_flags_i) |=> (status_o[W-2] == (result_o == '0)));
endmodule

// File: tb/cond_alu_bench.sv
module cond_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = 4'd0, cond_i = 4'hF;
  logic        set_flags_i = 1'b0, use_imm_i = 1'b0, shift_right_i = 1'b0;
  logic [4:0]  shift_amt_i = 5'd0;
  logic [31:0] opa_i = '0, opb_reg_i = '0, opb_imm_i = '0;
  logic [31:0] result_o, status_o;
  logic        wr_en_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  cond_alu u_cond_alu (.*);

  always #4 clk = ~clk;

  // {op, cond, S, a, b, expected result, expected write, expected NZCV}
  localparam int NV = 17;
  localparam logic [109:0] VEC [NV] = '{
    {4'd0, 4'hE, 1'b1, 32'h00000001, 32'h00000002, 32'h00000003, 1'b1, 4'b0000}, // R4 add
    {4'd1, 4'hE, 1'b1, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 4'b0110}, // R4 sub zero
    {4'd0, 4'h0, 1'b0, 32'h0000000A, 32'h00000014, 32'h0000001E, 1'b1, 4'b0110}, // R2 EQ pass
    {4'd0, 4'h1, 1'b0, 32'h00000007, 32'h00000007, 32'h0000001E, 1'b0, 4'b0110}, // R1 NE fail
    {4'd5, 4'hE, 1'b0, 32'h02FA62CA, 32'h0000FFFF, 32'h02FA0000, 1'b1, 4'b0110}, // R5 bit-clear
    {4'd8, 4'hE, 1'b0, 32'h00000003, 32'h00000005, 32'h02FA0000, 1'b0, 4'b1000}, // R7 compare
    {4'd0, 4'hC, 1'b0, 32'h00000001, 32'h00000001, 32'h02FA0000, 1'b0, 4'b1000}, // R2 GT fail
    {4'd0, 4'hB, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 4'b1001}, // R4 overflow, LT
    {4'd0, 4'hC, 1'b0, 32'h00000002, 32'h00000002, 32'h00000004, 1'b1, 4'b1001}, // R2 GT pass
    {4'd7, 4'hE, 1'b1, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b1, 4'b1001}, // R5 move-negated
    {4'd4, 4'hE, 1'b1, 32'hF0F0F0F0, 32'hF0F0F0F0, 32'h00000000, 1'b1, 4'b0101}, // R9 xor zero
    {4'd3, 4'hF, 1'b1, 32'h00000001, 32'h00000002, 32'h00000000, 1'b0, 4'b0101}, // R2 never
    {4'd0, 4'hE, 1'b1, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 4'b0110}, // R4 carry
    {4'd6, 4'hE, 1'b0, 32'h0000DEAD, 32'h12345678, 32'h12345678, 1'b1, 4'b0110}, // R6 move no S
    {4'd2, 4'h2, 1'b0, 32'hFF00FF00, 32'h0F0F0F0F, 32'h0F000F00, 1'b1, 4'b0110}, // R5 and, CS
    {4'd1, 4'hE, 1'b1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 4'b0011}, // R4 sub overflow
    {4'd3, 4'h6, 1'b0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b1, 4'b0011}  // R2 VS pass
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [3:0] cc, input logic s,
                        input logic imm_sel, input logic dir, input logic [4:0] amt,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] imm);
    op_i = op; cond_i = cc; set_flags_i = s; use_imm_i = imm_sel;
    shift_right_i = dir; shift_amt_i = amt; opa_i = a; opb_reg_i = b; opb_imm_i = imm;
    @(posedge clk);
    @(negedge clk);
    op_i = 4'd0; cond_i = 4'hF;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state
    check("R3 reset status", status_o, 32'h0);
    check("R3 reset result", result_o, 32'h0);
    check("R3 reset wr_en", {31'b0, wr_en_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][109:106], VEC[i][105:102], VEC[i][101], 1'b0, 1'b0, 5'd0,
             VEC[i][100:69], VEC[i][68:37], 32'h0);
      check($sformatf("R10 vec%0d result", i), result_o, VEC[i][36:5]);
      check($sformatf("R1 vec%0d wr_en", i), {31'b0, wr_en_o}, {31'b0, VEC[i][4]});
      check($sformatf("R3 vec%0d status", i), status_o, {VEC[i][3:0], 28'h0});
    end

    // R8 left shift by 4 multiplies by 16
    run_op(4'd6, 4'hE, 1'b0, 1'b0, 1'b0, 5'd4, 32'h0, 32'h3, 32'h0);
    check("R8 shift left", result_o, 32'h30);
    // R8 immediate select
    run_op(4'd0, 4'hE, 1'b0, 1'b1, 1'b0, 5'd0, 32'h3, 32'd999, 32'd17);
    check("R8 immediate", result_o, 32'd20);
    // R9 carry from left shift, V kept
    run_op(4'd6, 4'hE, 1'b1, 1'b0, 1'b0, 5'd1, 32'h0, 32'h80000001, 32'h0);
    check("R9 shl result", result_o, 32'h2);
    check("R9 shl flags", status_o, 32'h30000000);
    // R9 carry from right shift, zero result
    run_op(4'd6, 4'hE, 1'b1, 1'b0, 1'b1, 5'd1, 32'h0, 32'h1, 32'h0);
    check("R9 shr flags", status_o, 32'h70000000);
    // R8 logical right shift by 31
    run_op(4'd6, 4'hE, 1'b0, 1'b0, 1'b1, 5'd31, 32'h0, 32'h80000000, 32'h0);
    check("R8 shift right", result_o, 32'h1);
    // R5 undefined opcode: no write, no flag change
    run_op(4'hC, 4'hE, 1'b1, 1'b0, 1'b0, 5'd0, 32'h1, 32'h1, 32'h0);
    check("R5 undef wr_en", {31'b0, wr_en_o}, 32'h0);
    check("R5 undef result", result_o, 32'h1);
    check("R5 undef flags", status_o, 32'h70000000);
    // R9 zero shift keeps carry
    run_op(4'd4, 4'hE, 1'b1, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 32'h0);
    check("R9 amt0 flags", status_o, 32'h70000000);
    // R3 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R3 rerun status", status_o, 32'h0);
    check("R3 rerun result", result_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule